// File: doc/BRIEF.md
# Multi-Precision Floating-Point Rounding Unit

This block takes an unrounded floating-point intermediate value, made of a sign, a 16-bit two's-complement unbiased exponent and a 67-bit mantissa, and rounds it to extended (64-bit significand), double (53-bit) or single (24-bit) precision. It supports the four IEEE 754 rounding directions. The 67-bit mantissa is a 64-bit significand with an explicit integer bit, followed by three extra bits: guard, round and sticky. The guard, round and sticky positions used for rounding move with the selected precision.

The result always stays in extended format. At single or double precision, every significand bit below the precision boundary is forced to zero, and the exponent is checked against that precision's range. An out-of-range result is either clamped (overflow) or flushed to a signed zero (underflow). An instruction-level override can force single or double rounding whatever the precision field says.

The datapath is combinational from the inputs to a single output register stage. `valid_o` follows `valid_i` one clock later. The output register loads only when `valid_i` is high.

Top module: `fp_round_unit`

## Requirements
- R1: While `rst_ni` is low, and until the first accepted input, `valid_o`, `sign_o`, `exp_o`, `mant_o`, `inexact_o`, `overflow_o` and `underflow_o` are all zero.
- R2: `valid_o` equals `valid_i` of the previous clock. The result outputs change only one clock after a cycle with `valid_i` high, and otherwise hold their values.
- R3: The precision in effect is chosen as follows. If `prec_ovr_i` is 01 (single) or 10 (double), that value is used. Otherwise `prec_i` decides: 00 extended, 01 single, 10 double, 11 extended. The significand widths are 24, 53 and 64 bits.
- R4: In the output significand, every bit below the selected precision is zero: `mant_o[39:0]` for single and `mant_o[10:0]` for double.
- R5: `rnd_mode_i` = 00 rounds to nearest. The result is incremented at its LSB when guard is 1 and at least one of LSB, round or sticky is 1. An exact tie therefore goes to the even value.
- R6: `rnd_mode_i` = 01 rounds toward zero. It truncates, so the kept bits leave unchanged.
- R7: `rnd_mode_i` = 10 rounds toward minus infinity and increments only negative inexact values. `rnd_mode_i` = 11 rounds toward plus infinity and increments only positive inexact values.
- R8: If the increment carries out of the significand, the significand becomes 1 followed by zeros, and the exponent goes up by one.
- R9: At the selected precision, `inexact_o` is the OR of the guard bit, the round bit and every lower input bit. It is also set on overflow or underflow.
- R10: Overflow occurs when the rounded exponent is above 127, 1023 or 16383 for single, double or extended. It sets `overflow_o`. The result is infinity (exponent 16384, mantissa 0) for round to nearest, and for a directed mode that rounds away from zero for that sign. Otherwise the result is the largest finite value: the precision's maximum exponent, with the top significand bits of that precision all ones.
- R11: Underflow occurs when the rounded exponent is below -126, -1022 or -16382. It sets `underflow_o`. The result is a zero with the input sign: exponent 0 and mantissa 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input value present |
| sign_i | input | 1 | Sign of the intermediate value |
| exp_i | input | 16 | Unbiased two's-complement exponent |
| mant_i | input | 67 | Significand [66:3], guard [2], round [1], sticky [0] |
| rnd_mode_i | input | 2 | Rounding direction code |
| prec_i | input | 2 | Precision code |
| prec_ovr_i | input | 2 | Instruction precision override (01 single, 10 double, others none) |
| valid_o | output | 1 | Result present |
| sign_o | output | 1 | Result sign |
| exp_o | output | 16 | Result unbiased exponent |
| mant_o | output | 64 | Result significand |
| inexact_o | output | 1 | Rounding discarded non-zero bits |
| overflow_o | output | 1 | Rounded exponent above range |
| underflow_o | output | 1 | Rounded exponent below range |

## Verification
The properties assume that every accepted mantissa is normalized, with `mant_i[66]` set, since no zero or denormal handling exists. The stimulus always drives that bit high.

The properties also take the input exponent as already meaningful for extended format. Random exponents are drawn from bands around each precision's limits, together with values at and just beyond the extended limits, so that carry-driven overflow and underflow at the boundary are both reached.

// File: rtl/fp_round_pkg.sv
package fp_round_pkg;
  localparam int EXP_W  = 16;
  localparam int SIG_W  = 64;
  localparam int MANT_W = SIG_W + 3;
  localparam int PW     = 7;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_NEG  = 2'b10,
    RND_POS  = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    PREC_EXT = 2'b00,
    PREC_SGL = 2'b01,
    PREC_DBL = 2'b10,
    PREC_RSV = 2'b11
  } prec_e;

  typedef struct packed {
    logic             sign;
    logic [EXP_W-1:0] exp;
    logic [SIG_W-1:0] mant;
    logic             inexact;
    logic             ovf;
    logic             unf;
  } res_t;
endpackage

// File: rtl/fp_round_prec_sel.sv
module fp_round_prec_sel
  import fp_round_pkg::*;
#(
  parameter int SGL_BITS = 24,
  parameter int DBL_BITS = 53,
  parameter int SGL_EMAX = 127,
  parameter int DBL_EMAX = 1023,
  parameter int EXT_EMAX = 16383
) (
  input  logic [1:0]              prec_i,
  input  logic [1:0]              ovr_i,
  output logic [PW-1:0]           bits_o,
  output logic signed [EXP_W:0]   emax_o,
  output logic signed [EXP_W:0]   emin_o
);
  prec_e sel;

  always_comb begin
    // override wins when it names single or double
    if (ovr_i == PREC_SGL || ovr_i == PREC_DBL) sel = prec_e'(ovr_i);
    else                                        sel = prec_e'(prec_i);
    case (sel)
      PREC_SGL: begin
        bits_o = PW'(SGL_BITS);
        emax_o = (EXP_W+1)'(SGL_EMAX);
      end
      PREC_DBL: begin
        bits_o = PW'(DBL_BITS);
        emax_o = (EXP_W+1)'(DBL_EMAX);
      end
      default: begin
        bits_o = PW'(SIG_W);
        emax_o = (EXP_W+1)'(EXT_EMAX);
      end
    endcase
    emin_o = (EXP_W+1)'(1) - emax_o;
  end
endmodule

// File: rtl/fp_round_core.sv
module fp_round_core
  import fp_round_pkg::*;
(
  input  logic              sign_i,
  input  logic [1:0]        rnd_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [PW-1:0]     bits_i,
  output logic [SIG_W-1:0]  mant_o,
  output logic              carry_o,
  output logic              inexact_o
);
  logic [SIG_W-1:0]  keep_mask;
  logic [MANT_W-1:0] stk_mask;
  logic [MANT_W-1:0] sh_v;
  logic [SIG_W:0]    inc_v;
  logic [SIG_W:0]    sum;
  logic              lsb, grd, rbit, stk, up;
  int                p;

  always_comb begin
    p = int'(bits_i);
    for (int i = 0; i < SIG_W; i++)  keep_mask[i] = (i >= SIG_W - p);
    for (int i = 0; i < MANT_W; i++) stk_mask[i]  = (i < MANT_W - 2 - p);
    // align round bit to position 0
    sh_v = mant_i >> (MANT_W - 2 - p);
    rbit = sh_v[0];
    grd  = sh_v[1];
    lsb  = sh_v[2];
    stk  = |(mant_i & stk_mask);
    inexact_o = grd | rbit | stk;
    case (rnd_mode_e'(rnd_i))
      RND_NEAR: up = grd & (lsb | rbit | stk);
      RND_ZERO: up = 1'b0;
      RND_NEG:  up = inexact_o & sign_i;
      RND_POS:  up = inexact_o & ~sign_i;
      default:  up = 1'b0;
    endcase
    inc_v   = {{SIG_W{1'b0}}, up} << (SIG_W - p);
    sum     = {1'b0, mant_i[MANT_W-1:3] & keep_mask} + inc_v;
    carry_o = sum[SIG_W];
    mant_o  = carry_o ? sum[SIG_W:1] : sum[SIG_W-1:0];
  end
endmodule

// File: rtl/fp_round_range.sv
module fp_round_range
  import fp_round_pkg::*;
#(
  parameter int EXT_EMAX = 16383
) (
  input  logic                  sign_i,
  input  logic [1:0]            rnd_i,
  input  logic [EXP_W-1:0]      exp_i,
  input  logic                  carry_i,
  input  logic [SIG_W-1:0]      mant_i,
  input  logic                  inexact_i,
  input  logic [PW-1:0]         bits_i,
  input  logic signed [EXP_W:0] emax_i,
  input  logic signed [EXP_W:0] emin_i,
  output res_t                  res_o
);
  logic signed [EXP_W:0] e;
  logic [SIG_W-1:0]      max_m;
  logic                  to_inf;

  always_comb begin
    e     = $signed({exp_i[EXP_W-1], exp_i}) + $signed({{EXP_W{1'b0}}, carry_i});
    max_m = {SIG_W{1'b1}} << (SIG_W - int'(bits_i));
    case (rnd_mode_e'(rnd_i))
      RND_NEAR: to_inf = 1'b1;
      RND_ZERO: to_inf = 1'b0;
      RND_NEG:  to_inf = sign_i;
      RND_POS:  to_inf = ~sign_i;
      default:  to_inf = 1'b1;
    endcase
    res_o.sign    = sign_i;
    res_o.exp     = e[EXP_W-1:0];
    res_o.mant    = mant_i;
    res_o.inexact = inexact_i;
    res_o.ovf     = 1'b0;
    res_o.unf     = 1'b0;
    if (e > emax_i) begin
      res_o.ovf     = 1'b1;
      res_o.inexact = 1'b1;
      if (to_inf) begin
        res_o.exp  = EXP_W'(EXT_EMAX + 1);
        res_o.mant = '0;
      end else begin
        res_o.exp  = emax_i[EXP_W-1:0];
        res_o.mant = max_m;
      end
    end else if (e < emin_i) begin
      res_o.unf     = 1'b1;
      res_o.inexact = 1'b1;
      res_o.exp     = '0;
      res_o.mant    = '0;
    end
  end
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fp_round_pkg::*;
#(
  parameter int SGL_BITS = 24,
  parameter int DBL_BITS = 53,
  parameter int SGL_EMAX = 127,
  parameter int DBL_EMAX = 1023,
  parameter int EXT_EMAX = 16383
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [1:0]        rnd_mode_i,
  input  logic [1:0]        prec_i,
  input  logic [1:0]        prec_ovr_i,
  output logic              valid_o,
  output logic              sign_o,
  output logic [EXP_W-1:0]  exp_o,
  output logic [SIG_W-1:0]  mant_o,
  output logic              inexact_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic [PW-1:0]         bits;
  logic signed [EXP_W:0] emax, emin;
  logic [SIG_W-1:0]      mant_r;
  logic                  carry, inexact;
  res_t                  res_d, res_q;

  fp_round_prec_sel #(
    .SGL_BITS(SGL_BITS), .DBL_BITS(DBL_BITS),
    .SGL_EMAX(SGL_EMAX), .DBL_EMAX(DBL_EMAX), .EXT_EMAX(EXT_EMAX)
  ) u_sel (
    .prec_i(prec_i), .ovr_i(prec_ovr_i),
    .bits_o(bits), .emax_o(emax), .emin_o(emin)
  );

  fp_round_core u_core (
    .sign_i(sign_i), .rnd_i(rnd_mode_i), .mant_i(mant_i), .bits_i(bits),
    .mant_o(mant_r), .carry_o(carry), .inexact_o(inexact)
  );

  fp_round_range #(.EXT_EMAX(EXT_EMAX)) u_range (
    .sign_i(sign_i), .rnd_i(rnd_mode_i), .exp_i(exp_i), .carry_i(carry),
    .mant_i(mant_r), .inexact_i(inexact), .bits_i(bits),
    .emax_i(emax), .emin_i(emin), .res_o(res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign sign_o      = res_q.sign;
  assign exp_o       = res_q.exp;
  assign mant_o      = res_q.mant;
  assign inexact_o   = res_q.inexact;
  assign overflow_o  = res_q.ovf;
  assign underflow_o = res_q.unf;
endmodule

// File: rtl/fp_round_unit_chk.sv
module fp_round_unit_chk
  import fp_round_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              sign_i,
  input logic [EXP_W-1:0]  exp_i,
  input logic [MANT_W-1:0] mant_i,
  input logic [1:0]        rnd_mode_i,
  input logic [1:0]        prec_i,
  input logic [1:0]        prec_ovr_i,
  input logic              valid_o,
  input logic              sign_o,
  input logic [EXP_W-1:0]  exp_o,
  input logic [SIG_W-1:0]  mant_o,
  input logic              inexact_o,
  input logic              overflow_o,
  input logic              underflow_o
);
  logic is_sgl, is_dbl, is_ext, exp_mid;
  always_comb begin
    is_sgl  = (prec_ovr_i == 2'b01) || (prec_ovr_i != 2'b10 && prec_i == 2'b01);
    is_dbl  = (prec_ovr_i == 2'b10) || (prec_ovr_i != 2'b01 && prec_i == 2'b10);
    is_ext  = !is_sgl && !is_dbl;
    exp_mid = ($signed(exp_i) < 16'sd100) && ($signed(exp_i) > -16'sd100);
  end

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(mant_o) && $stable(exp_o) && $stable(sign_o));

  assert_sgl_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_sgl |=> mant_o[39:0] == '0);

  assert_dbl_low_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_dbl |=> mant_o[10:0] == '0);

  assert_exact_ext_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_ext && mant_i[2:0] == 3'b000 && exp_mid |=>
      !inexact_o && mant_o == $past(mant_i[MANT_W-1:3]));

  assert_rz_no_inf_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && rnd_mode_i == 2'b01 |=> !(exp_o == 16'h4000 && mant_o == '0));

  assert_flags_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(overflow_o && underflow_o));

  assert_ovf_inexact_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overflow_o || underflow_o) |-> inexact_o);

  assert_norm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && mant_i[MANT_W-1] |=> underflow_o || mant_o[SIG_W-1] || mant_o == '0);

  assert_unf_sign_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !underflow_o || (sign_o == $past(sign_i) && mant_o == '0));
endmodule

bind fp_round_unit fp_round_unit_chk u_chk (.*);

// File: tb/fp_round_unit_bench.sv
module fp_round_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [15:0] exp_i = '0;
  logic [66:0] mant_i = '0;
  logic [1:0]  rnd_mode_i = '0, prec_i = '0, prec_ovr_i = '0;
  logic        valid_o, sign_o, inexact_o, overflow_o, underflow_o;
  logic [15:0] exp_o;
  logic [63:0] mant_o;

  fp_round_unit u_fp_round_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .sign_i(sign_i),
    .exp_i(exp_i), .mant_i(mant_i), .rnd_mode_i(rnd_mode_i), .prec_i(prec_i),
    .prec_ovr_i(prec_ovr_i), .valid_o(valid_o), .sign_o(sign_o), .exp_o(exp_o),
    .mant_o(mant_o), .inexact_o(inexact_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          vld;
    bit          s;
    int          e;
    logic [63:0] m;
    bit          ix, ov, un;
    int          p;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t held;
  int   n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t model(input bit s, input logic [15:0] e16, input logic [66:0] m,
                                 input logic [1:0] rnd, input logic [1:0] prec,
                                 input logic [1:0] ovr, input string tag);
    exp_t r;
    int p, emax, sh, e;
    logic [66:0] kept, rem, half;
    bit up, inx, inf;
    if (ovr == 2'd1) p = 24;
    else if (ovr == 2'd2) p = 53;
    else if (prec == 2'd1) p = 24;
    else if (prec == 2'd2) p = 53;
    else p = 64;
    emax = (p == 24) ? 127 : (p == 53) ? 1023 : 16383;
    sh   = 67 - p;
    kept = m >> sh;
    rem  = m & ((67'd1 << sh) - 67'd1);
    half = 67'd1 << (sh - 1);
    inx  = (rem != 0);
    case (rnd)
      2'd0: up = (rem > half) || (rem == half && kept[0]);
      2'd1: up = 1'b0;
      2'd2: up = inx && s;
      default: up = inx && !s;
    endcase
    e = int'($signed(e16));
    if (up) begin
      kept = kept + 67'd1;
      if (kept == (67'd1 << p)) begin
        kept = 67'd1 << (p - 1);
        e = e + 1;
      end
    end
    r.vld = 1; r.s = s; r.p = p; r.tag = tag;
    r.m = 64'(kept << (64 - p));
    r.e = e; r.ix = inx; r.ov = 0; r.un = 0;
    if (e > emax) begin
      r.ov = 1; r.ix = 1;
      inf = (rnd == 2'd0) || (rnd == 2'd2 && s) || (rnd == 2'd3 && !s);
      if (inf) begin r.e = 16384; r.m = '0; end
      else begin r.e = emax; r.m = ~64'd0 << (64 - p); end
    end else if (e < 1 - emax) begin
      r.un = 1; r.ix = 1; r.e = 0; r.m = '0;
    end
    return r;
  endfunction

  task automatic check_out();
    exp_t x;
    logic [63:0] low;
    if (q.size() == 0) return;
    x = q.pop_front();
    chk(valid_o == x.vld, "R2", "valid_o", longint'(valid_o), longint'(x.vld));
    if (!x.vld) x = held;  // R2: outputs hold without a new input
    else held = x;
    chk(sign_o == x.s, x.tag, "sign_o", longint'(sign_o), longint'(x.s));
    chk($signed(exp_o) == 16'(x.e), x.tag, "exp_o", longint'(exp_o), longint'(16'(x.e)));
    chk(mant_o == x.m, x.tag, "mant_o", longint'(mant_o), longint'(x.m));
    chk(inexact_o == x.ix, "R9", "inexact_o", longint'(inexact_o), longint'(x.ix));
    chk(overflow_o == x.ov, "R10", "overflow_o", longint'(overflow_o), longint'(x.ov));
    chk(underflow_o == x.un, "R11", "underflow_o", longint'(underflow_o), longint'(x.un));
    low = (x.p == 64) ? 64'd0 : ((64'd1 << (64 - x.p)) - 64'd1);
    chk((mant_o & low) == 0, "R4", "low bits", longint'(mant_o & low), 0);
  endtask

  task automatic step(input bit v, input bit s, input int e, input logic [66:0] m,
                      input logic [1:0] rnd, input logic [1:0] prec,
                      input logic [1:0] ovr, input string tag);
    exp_t x;
    @(negedge clk);
    check_out();
    valid_i = v; sign_i = s; exp_i = 16'(e); mant_i = m;
    rnd_mode_i = rnd; prec_i = prec; prec_ovr_i = ovr;
    if (v) x = model(s, 16'(e), m, rnd, prec, ovr, tag);
    else begin x = held; x.vld = 0; end
    q.push_back(x);
  endtask

  localparam logic [66:0] ONE   = 67'd1 << 66;
  localparam logic [66:0] ONES  = ~67'd0;

  initial begin
    bit done = 0;
    fork
      begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog expired");
          $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
          $finish;
        end
      end
      begin
        held = '{0, 0, 0, 64'd0, 0, 0, 0, 64, "R1"};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(valid_o == 0 && sign_o == 0 && exp_o == 0 && mant_o == 0 &&
            inexact_o == 0 && overflow_o == 0 && underflow_o == 0,
            "R1", "reset outputs", longint'(mant_o), 0);
        rst_ni = 1'b1;
        // R3: precision selection and override
        step(1, 0, 5, ONE | 67'h7, 2'd1, 2'd3, 2'd0, "R3");
        step(1, 0, 5, ONE | (67'd1 << 42), 2'd3, 2'd0, 2'd1, "R3");
        step(1, 1, 5, ONE | (67'd1 << 12), 2'd2, 2'd1, 2'd2, "R3");
        // R5: ties to even, down then up
        step(1, 0, 0, ONE | (67'd1 << 42), 2'd0, 2'd1, 2'd0, "R5");
        step(1, 0, 0, ONE | (67'd3 << 42), 2'd0, 2'd1, 2'd0, "R5");
        step(1, 0, 0, ONE | (67'd1 << 2), 2'd0, 2'd0, 2'd0, "R5");
        // R6 / R7: direction against sign
        step(1, 1, 3, ONE | 67'd1, 2'd1, 2'd0, 2'd0, "R6");
        step(1, 1, 3, ONE | 67'd1, 2'd2, 2'd0, 2'd0, "R7");
        step(1, 0, 3, ONE | 67'd1, 2'd2, 2'd0, 2'd0, "R7");
        step(1, 0, 3, ONE | 67'd1, 2'd3, 2'd2, 2'd0, "R7");
        // R8: carry out of significand
        step(1, 0, 10, ONES, 2'd0, 2'd0, 2'd0, "R8");
        step(1, 1, -7, ONES, 2'd2, 2'd1, 2'd0, "R8");
        // R2: idle cycles hold
        step(0, 1, 99, ONES, 2'd3, 2'd2, 2'd0, "R2");
        step(0, 0, -99, ONE, 2'd0, 2'd1, 2'd0, "R2");
        // R10: overflow in each mode
        step(1, 0, 127, ONES, 2'd0, 2'd1, 2'd0, "R10");
        step(1, 0, 200, ONE, 2'd2, 2'd1, 2'd0, "R10");
        step(1, 1, 200, ONE, 2'd1, 2'd1, 2'd0, "R10");
        step(1, 1, 200, ONE, 2'd3, 2'd2, 2'd0, "R10");
        step(1, 1, 2000, ONE, 2'd2, 2'd2, 2'd0, "R10");
        step(1, 0, 16383, ONES, 2'd0, 2'd0, 2'd0, "R10");
        step(1, 0, 16383, ONES, 2'd1, 2'd0, 2'd0, "R10");
        // R11: underflow, including a carry that rescues it
        step(1, 1, -127, ONE, 2'd0, 2'd1, 2'd0, "R11");
        step(1, 0, -16383, ONES, 2'd1, 2'd0, 2'd0, "R11");
        step(1, 0, -16383, ONES, 2'd0, 2'd0, 2'd0, "R11");
        step(1, 1, -1023, ONES, 2'd2, 2'd2, 2'd0, "R11");
        // random sweep
        for (int n = 0; n < 3000; n++) begin
          logic [66:0] m;
          int e, band;
          logic [1:0] rnd;
          string tag;
          m = {3'b100, 32'($urandom), 32'($urandom)};
          if ($urandom_range(0, 3) == 0) m[2:0] = 3'b100;
          if ($urandom_range(0, 7) == 0) m[65:0] = ~66'd0;
          band = $urandom_range(0, 3);
          case (band)
            0: e = $urandom_range(0, 280) - 140;
            1: e = $urandom_range(0, 2080) - 1040;
            2: e = $urandom_range(0, 6) + 16379;
            default: e = -($urandom_range(0, 6) + 16379);
          endcase
          rnd = 2'($urandom_range(0, 3));
          tag = (rnd == 2'd0) ? "R5" : (rnd == 2'd1) ? "R6" : "R7";
          step($urandom_range(0, 7) != 0, 1'($urandom), e, m, rnd,
               2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), tag);
        end
        step(0, 0, 0, ONE, 2'd0, 2'd0, 2'd0, "R2");
        @(negedge clk);
        check_out();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join
  end
endmodule